// File: doc/BRIEF.md
# Per-Thread Register File with Launch Metadata

This block is the private operand store of a single SIMD thread. It holds sixteen 8-bit entries. Two read ports return any two entries combinationally in the same cycle. One write port updates a general-purpose entry on the rising clock edge. The thread's ALU, load path and immediate path all write through that single port. The logic that selects operands sits outside the block.

The three highest entries are not general storage. They hold values that the launch logic supplies: the block number, the number of threads per block, and this thread's position inside its block. These values are captured from dedicated inputs whenever the launch strobe is high. Kernel code can read them like any other register but cannot overwrite them. A write aimed at one of these entries is dropped without effect.

Top module: `thread_regfile`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first write or launch, every one of the 16 entries reads as zero on both ports.
- R2: A write with `wr_en_i` high to an address from 0 to 12 makes `wr_data_i` readable at that address on both ports from the cycle after the clock edge.
- R3: With `wr_en_i` low, no entry changes, whatever values `wr_addr_i` and `wr_data_i` carry.
- R4: A write with `wr_en_i` high to address 13, 14 or 15 changes no entry, neither a metadata entry nor a general-purpose one.
- R5: On a clock edge with `launch_i` high, address 13 takes `block_id_i`, address 14 takes `block_size_i` and address 15 takes `thread_idx_i`. These values are held until the next launch or reset. A write to those addresses in the same cycle does not override them.
- R6: The two read ports are independent: each returns the entry at its own address in the same cycle, including when both addresses are equal.
- R7: A read whose address equals the write address in the same cycle returns the value held before that write; the new value appears only after the clock edge.
- R8: A write changes only the addressed entry; all other general-purpose entries keep their values.
- R9: A launch does not change entries 0 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Launch strobe; captures the metadata inputs |
| block_id_i | input | 8 | Block number, captured into entry 13 |
| block_size_i | input | 8 | Threads per block, captured into entry 14 |
| thread_idx_i | input | 8 | Local thread index, captured into entry 15 |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_a_addr_i | input | 4 | Read port A address |
| rd_a_data_o | output | 8 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B address |
| rd_b_data_o | output | 8 | Read port B data |

## Verification
The bench builds the block with its default parameters: 16 entries of 8 bits, three of them metadata. At that size every address can be swept through the write port and read back through both ports. The full 8-bit data range can also be written to a single entry. This covers all 16 write targets, including the three protected ones, and every pairing of read addresses used in the sweep. A same-cycle read-during-write check and a write to a metadata entry in the same cycle as a launch test the two ordering cases that the address sweep does not reach.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  // Order of metadata entries above the general-purpose range
  typedef enum logic [1:0] {
    META_BLOCK_ID   = 2'd0,
    META_BLOCK_SIZE = 2'd1,
    META_THREAD_IDX = 2'd2
  } meta_slot_e;

  localparam int unsigned NUM_META = 3;
endpackage

// File: rtl/regfile_gp_bank.sv
module regfile_gp_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_GP = 13,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [NUM_GP-1:0][DATA_W-1:0]  gp_o
);

  logic [NUM_GP-1:0][DATA_W-1:0] gp_q;

  // Addresses at or above NUM_GP match no entry, so protected writes drop here
  for (genvar g = 0; g < NUM_GP; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      gp_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))      gp_q[g] <= wr_data_i;
    end
  end

  assign gp_o = gp_q;

  assert_gp_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(gp_q));

  assert_gp_protect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= ADDR_W'(NUM_GP)) |=> $stable(gp_q));

endmodule

// File: rtl/regfile_meta_bank.sv
module regfile_meta_bank
  import regfile_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             launch_i,
  input  logic [NUM_META-1:0][DATA_W-1:0]  meta_i,
  output logic [NUM_META-1:0][DATA_W-1:0]  meta_o
);

  logic [NUM_META-1:0][DATA_W-1:0] meta_q;

  for (genvar s = 0; s < NUM_META; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       meta_q[s] <= '0;
      else if (launch_i) meta_q[s] <= meta_i[s];
    end
  end

  assign meta_o = meta_q;

  assert_meta_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (meta_q == $past(meta_i)));

  assert_meta_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> $stable(meta_q));

endmodule

// File: rtl/regfile_read_port.sv
module regfile_read_port #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]               addr_i,
  output logic [DATA_W-1:0]               data_o
);

  // No write bypass: reads see register state only
  assign data_o = regs_i[addr_i];

endmodule

// File: rtl/thread_regfile.sv
module thread_regfile
  import regfile_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        launch_i,
  input  logic [DATA_W-1:0]           block_id_i,
  input  logic [DATA_W-1:0]           block_size_i,
  input  logic [DATA_W-1:0]           thread_idx_i,
  input  logic                        wr_en_i,
  input  logic [$clog2(NUM_REGS)-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [$clog2(NUM_REGS)-1:0] rd_a_addr_i,
  output logic [DATA_W-1:0]           rd_a_data_o,
  input  logic [$clog2(NUM_REGS)-1:0] rd_b_addr_i,
  output logic [DATA_W-1:0]           rd_b_data_o
);

  localparam int unsigned ADDR_W   = $clog2(NUM_REGS);
  localparam int unsigned NUM_GP   = NUM_REGS - NUM_META;
  localparam int unsigned NUM_RD   = 2;
  localparam logic [ADDR_W-1:0] META_BASE = ADDR_W'(NUM_GP);

  logic [NUM_GP-1:0][DATA_W-1:0]   gp_q;
  logic [NUM_META-1:0][DATA_W-1:0] meta_in;
  logic [NUM_META-1:0][DATA_W-1:0] meta_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] all_regs;
  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  always_comb begin
    meta_in                  = '0;
    meta_in[META_BLOCK_ID]   = block_id_i;
    meta_in[META_BLOCK_SIZE] = block_size_i;
    meta_in[META_THREAD_IDX] = thread_idx_i;
  end

  regfile_gp_bank #(
    .DATA_W (DATA_W),
    .NUM_GP (NUM_GP),
    .ADDR_W (ADDR_W)
  ) u_gp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .gp_o      (gp_q)
  );

  regfile_meta_bank #(
    .DATA_W (DATA_W)
  ) u_meta (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch_i),
    .meta_i   (meta_in),
    .meta_o   (meta_q)
  );

  assign all_regs = {meta_q, gp_q};
  assign rd_addr  = {rd_b_addr_i, rd_a_addr_i};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    regfile_read_port #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W)
    ) u_rd (
      .regs_i (all_regs),
      .addr_i (rd_addr[p]),
      .data_o (rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  assert_write_visible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i < META_BASE) |=>
      (rd_a_addr_i != $past(wr_addr_i)) || (rd_a_data_o == $past(wr_data_i)));

  assert_launch_keeps_gp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && !wr_en_i) |=> $stable(gp_q));

endmodule

// File: tb/sim_thread_regfile.sv
`timescale 1ns/1ps
module sim_thread_regfile;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       launch_i = 1'b0;
  logic [7:0] block_id_i = '0, block_size_i = '0, thread_idx_i = '0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] rd_a_addr_i = '0, rd_b_addr_i = '0;
  logic [7:0] rd_a_data_o, rd_b_data_o;

  logic [7:0] model [16];
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  thread_regfile u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .launch_i     (launch_i),
    .block_id_i   (block_id_i),
    .block_size_i (block_size_i),
    .thread_idx_i (thread_idx_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .rd_a_addr_i  (rd_a_addr_i),
    .rd_a_data_o  (rd_a_data_o),
    .rd_b_addr_i  (rd_b_addr_i),
    .rd_b_data_o  (rd_b_data_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Compare both ports against the model; addresses set away from the edge
  task automatic read_pair(input string req, input int a, input int b);
    rd_a_addr_i = 4'(a);
    rd_b_addr_i = 4'(b);
    #1;
    chk(req, rd_a_data_o, model[a]);
    chk(req, rd_b_data_o, model[b]);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 16; a++) read_pair(req, a, 15 - a);
  endtask

  task automatic do_write(input int addr, input logic [7:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 4'(addr); wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (addr < 13) model[addr] = data;
  endtask

  task automatic do_launch(input logic [7:0] bid, input logic [7:0] bsz, input logic [7:0] tid);
    @(negedge clk);
    launch_i = 1'b1; block_id_i = bid; block_size_i = bsz; thread_idx_i = tid;
    @(negedge clk);
    launch_i = 1'b0;
    model[13] = bid; model[14] = bsz; model[15] = tid;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;

    // R1: zero during and after reset
    #3;
    read_all("R1 in reset");
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    read_all("R1 after reset");

    // R5, R9: launch metadata, general entries untouched
    do_launch(8'h05, 8'h08, 8'h03);
    read_all("R5 R9 first launch");

    // R2, R4, R8: write every address, protected ones dropped
    for (int a = 0; a < 16; a++) begin
      do_write(a, 8'(a * 17 + 3));
      read_all("R2 R4 R8 sweep");
    end

    // R6: both ports on the same address
    for (int a = 0; a < 16; a++) read_pair("R6 same address", a, a);

    // R3: disabled write with live address/data
    @(negedge clk);
    wr_en_i = 1'b0; wr_addr_i = 4'd2; wr_data_i = 8'hFF;
    @(negedge clk);
    wr_addr_i = 4'd14; wr_data_i = 8'h77;
    @(negedge clk);
    read_all("R3 disabled write");

    // R7: read-during-write returns old value, new after the edge
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 4'd4; wr_data_i = 8'hAA;
    rd_a_addr_i = 4'd4; rd_b_addr_i = 4'd4;
    #1;
    chk("R7 port A old", rd_a_data_o, model[4]);
    chk("R7 port B old", rd_b_data_o, model[4]);
    @(negedge clk);
    wr_en_i = 1'b0;
    model[4] = 8'hAA;
    #1;
    chk("R7 R2 port A new", rd_a_data_o, 8'hAA);
    chk("R7 R2 port B new", rd_b_data_o, 8'hAA);

    // R5: launch concurrent with write to a metadata address
    @(negedge clk);
    launch_i = 1'b1; block_id_i = 8'h07; block_size_i = 8'h04; thread_idx_i = 8'h01;
    wr_en_i = 1'b1; wr_addr_i = 4'd14; wr_data_i = 8'hEE;
    @(negedge clk);
    launch_i = 1'b0; wr_en_i = 1'b0;
    model[13] = 8'h07; model[14] = 8'h04; model[15] = 8'h01;
    read_all("R5 R4 R9 launch with write");

    // R5: metadata held after inputs change without strobe
    @(negedge clk);
    block_id_i = 8'h99; block_size_i = 8'h99; thread_idx_i = 8'h99;
    @(negedge clk);
    read_all("R5 hold");

    // R2: full data range through one entry
    for (int d = 0; d < 256; d++) begin
      do_write(12, 8'(d));
      read_pair("R2 data sweep", 12, 11);
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    #1;
    read_all("R1 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    read_all("R1 after second reset");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule